// File: doc/BRIEF.md
# Peripheral Function Pad Router

This block connects each of a parameterized set of peripheral functions to any one pad in the numbered range 8 to 71. Every function owns a 7-bit selector. A selector of zero leaves the function unconnected. A value v from 1 to 64 attaches it to pad v+7. Two selectors share each 32-bit register word. Each selector has its own byte lane of write-enable (mask) bits, so one function can be retargeted without a read-modify-write of its neighbour.

On the output side, the block forwards the function's output value and output enable onto the chosen pad. It does so only when that pad's ownership bit gives the pad to the peripheral side. If several functions name the same pad, the lowest-numbered function wins. On the input side, each routed function receives the live level of its pad. An unrouted function receives a constant 0. Software programs the selectors through a simple synchronous write and read port.

Top module: `fpmx_router`

## Requirements
- R1: After reset every selector is 0, no pad is driven (`pad_out` and `pad_oe` all 0), every `fn_in` bit is 0, and `bus_rdata` is 0.
- R2: Function 2k lives in the word at byte address 4k. Its selector is in bits 6:0, with write-enable bits 22:16. Function 2k+1 uses bits 14:8, with write-enable bits 30:24. Address bits 1:0 are ignored.
- R3: A write changes a selector bit only when the matching write-enable bit is 1 in that same write. A write whose write-enable bits for a function are all 0 leaves that function's selector unchanged.
- R4: A cycle with `bus_rd` high loads `bus_rdata` on the next clock edge. The loaded value holds the addressed word's two selectors in bits 6:0 and 14:8, with all other bits 0. A read of an address beyond the last word returns 0.
- R5: Take a function whose selector v is in 1..64, with `pad_gpio_own[v+7]` equal to 0. From the clock edge that stores v, pad v+7 carries that function's `fn_out` on `pad_out` and its `fn_oe` on `pad_oe`. A pad that no function drives has `pad_out` and `pad_oe` at 0.
- R6: A pad whose `pad_gpio_own` bit is 1 has `pad_out` and `pad_oe` at 0, whatever the selectors hold.
- R7: When several functions select the same pad, only the lowest-numbered one drives it.
- R8: A selector of 0, or any value above 64, drives no pad and gives `fn_in` = 0 for that function.
- R9: A routed function's `fn_in` follows `pad_in` of its selected pad, whatever that pad's ownership bit is.
- R10: Writing 0 to a selector detaches the function from its pad. A higher-numbered function that selects the same pad then takes the pad over.
- R11: A write to an address beyond the last word changes no selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data, with write-enable lanes in the upper half |
| bus_rdata | output | 32 | Registered read data |
| fn_out | input | NUM_FUNCS | Output value from each function |
| fn_oe | input | NUM_FUNCS | Output enable from each function |
| fn_in | output | NUM_FUNCS | Pad level returned to each function |
| pad_gpio_own | input | NUM_PADS | 1 gives the pad to the GPIO side, 0 to the peripheral side |
| pad_in | input | NUM_PADS | Pad input levels |
| pad_out | output | NUM_PADS | Pad output value |
| pad_oe | output | NUM_PADS | Pad output enable |

## Verification
The bench routes functions to the two end pads, 8 and 71, and then to an interior pad. Each function carries a distinct `fn_out`/`fn_oe` pattern, so a route to the wrong pad or a mix-up between odd and even lanes shows up. Partial and empty write-enable masks separate correct lane gating from whole-word writes. Two functions aimed at one pad, with one then cleared, separate the fixed priority from a last-writer rule. Ownership flips, out-of-range selectors and out-of-range addresses show that each path blocks its own effect and nothing more.

// File: rtl/fpmx_pkg.sv
package fpmx_pkg;
  localparam int SEL_W      = 7;
  localparam int PAD_FIRST  = 8;
  localparam int PAD_SPAN   = 64;
  localparam int LANE_W     = 8;
  localparam int MASK_SHIFT = 16;

  typedef logic [SEL_W-1:0] sel_t;

  // selector is a live route when it names a pad inside the span
  function automatic logic sel_valid(sel_t s);
    return (s != '0) && (s <= SEL_W'(PAD_SPAN));
  endfunction

  // pad number addressed by a selector value
  function automatic int sel_pad(sel_t s);
    return int'(s) + PAD_FIRST - 1;
  endfunction
endpackage

// File: rtl/fpmx_sel_regs.sv
module fpmx_sel_regs
  import fpmx_pkg::*;
#(
  parameter int NUM_FUNCS = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_wr,
  input  logic                              bus_rd,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [31:0]                       bus_wdata,
  output logic [31:0]                       bus_rdata,
  output logic [NUM_FUNCS-1:0][SEL_W-1:0]   sel_o
);
  localparam int NUM_WORDS = NUM_FUNCS / 2;

  logic [NUM_FUNCS-1:0][SEL_W-1:0] sel_q, sel_d;
  logic [31:0] rdata_q, rdata_d;
  int          word_idx;
  logic        in_range;

  assign word_idx = int'(bus_addr >> 2);
  assign in_range = (word_idx < NUM_WORDS);

  // next-state: masked lane update
  always_comb begin
    sel_d = sel_q;
    if (bus_wr && in_range) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (word_idx == w) begin
          for (int l = 0; l < 2; l++) begin
            for (int b = 0; b < SEL_W; b++) begin
              if (bus_wdata[MASK_SHIFT + LANE_W*l + b])
                sel_d[2*w + l][b] = bus_wdata[LANE_W*l + b];
            end
          end
        end
      end
    end
  end

  // read data next-state
  always_comb begin
    rdata_d = '0;
    if (in_range) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (word_idx == w) begin
          rdata_d[SEL_W-1:0]               = sel_q[2*w];
          rdata_d[LANE_W +: SEL_W]         = sel_q[2*w + 1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      rdata_q <= '0;
    end else begin
      sel_q <= sel_d;
      if (bus_rd) rdata_q <= rdata_d;
    end
  end

  assign sel_o     = sel_q;
  assign bus_rdata = rdata_q;

  // R3: an empty write-enable lane keeps its selector
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_lane_chk
    a_r3_even_lane_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && in_range && word_idx == w && bus_wdata[MASK_SHIFT +: SEL_W] == '0)
      |=> $stable(sel_q[2*w]));
    a_r3_odd_lane_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && in_range && word_idx == w
       && bus_wdata[MASK_SHIFT + LANE_W +: SEL_W] == '0)
      |=> $stable(sel_q[2*w + 1]));
  end

  // R11: writes outside the word range leave every selector alone
  a_r11_stray_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !in_range) |=> $stable(sel_q));
endmodule

// File: rtl/fpmx_pad_xbar.sv
module fpmx_pad_xbar
  import fpmx_pkg::*;
#(
  parameter int NUM_FUNCS = 32,
  parameter int NUM_PADS  = 72
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_FUNCS-1:0][SEL_W-1:0] sel_i,
  input  logic [NUM_PADS-1:0]             pad_gpio_own,
  input  logic [NUM_FUNCS-1:0]            fn_out,
  input  logic [NUM_FUNCS-1:0]            fn_oe,
  output logic [NUM_PADS-1:0]             pad_out,
  output logic [NUM_PADS-1:0]             pad_oe
);
  logic [NUM_PADS-1:0][NUM_FUNCS-1:0] win;

  // priority pick: first function (lowest index) naming the pad
  always_comb begin
    logic taken;
    win = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      taken = 1'b0;
      for (int f = 0; f < NUM_FUNCS; f++) begin
        if (!taken && sel_valid(sel_i[f]) && sel_pad(sel_i[f]) == p) begin
          win[p][f] = 1'b1;
          taken     = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PADS; p++) begin
      pad_out[p] = !pad_gpio_own[p] && |(win[p] & fn_out);
      pad_oe[p]  = !pad_gpio_own[p] && |(win[p] & fn_oe);
    end
  end

  // R6: pads given to the GPIO side stay undriven
  a_r6_gpio_pad_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out) & pad_gpio_own) == '0);

  // R5: pads below the span are never driven
  a_r5_low_pads_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe[PAD_FIRST-1:0] == '0) && (pad_out[PAD_FIRST-1:0] == '0));

  // R7: at most one function drives any pad
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_win_chk
    a_r7_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win[p]));
  end
endmodule

// File: rtl/fpmx_in_route.sv
module fpmx_in_route
  import fpmx_pkg::*;
#(
  parameter int NUM_FUNCS = 32,
  parameter int NUM_PADS  = 72
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_FUNCS-1:0][SEL_W-1:0] sel_i,
  input  logic [NUM_PADS-1:0]             pad_in,
  output logic [NUM_FUNCS-1:0]            fn_in
);
  always_comb begin
    for (int f = 0; f < NUM_FUNCS; f++) begin
      fn_in[f] = 1'b0;
      for (int p = 0; p < NUM_PADS; p++) begin
        if (sel_valid(sel_i[f]) && sel_pad(sel_i[f]) == p)
          fn_in[f] = pad_in[p];
      end
    end
  end

  // R8: an unrouted function reads a constant 0
  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_in_chk
    a_r8_unrouted_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid(sel_i[f]) |-> !fn_in[f]);
  end
endmodule

// File: rtl/fpmx_router.sv
module fpmx_router
  import fpmx_pkg::*;
#(
  parameter int NUM_FUNCS = 32,
  parameter int NUM_PADS  = 72,
  parameter int ADDR_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_FUNCS-1:0]  fn_out,
  input  logic [NUM_FUNCS-1:0]  fn_oe,
  output logic [NUM_FUNCS-1:0]  fn_in,
  input  logic [NUM_PADS-1:0]   pad_gpio_own,
  input  logic [NUM_PADS-1:0]   pad_in,
  output logic [NUM_PADS-1:0]   pad_out,
  output logic [NUM_PADS-1:0]   pad_oe
);
  logic [NUM_FUNCS-1:0][SEL_W-1:0] sel;

  fpmx_sel_regs #(.NUM_FUNCS(NUM_FUNCS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sel_o(sel)
  );

  fpmx_pad_xbar #(.NUM_FUNCS(NUM_FUNCS), .NUM_PADS(NUM_PADS)) u_xbar (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .pad_gpio_own(pad_gpio_own),
    .fn_out(fn_out), .fn_oe(fn_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  fpmx_in_route #(.NUM_FUNCS(NUM_FUNCS), .NUM_PADS(NUM_PADS)) u_in (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .pad_in(pad_in), .fn_in(fn_in)
  );
endmodule

// File: tb/fpmx_router_tb.sv
module fpmx_router_tb_top;
  localparam int NF = 32;
  localparam int NP = 72;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NF-1:0] fn_out, fn_oe, fn_in;
  logic [NP-1:0] pad_gpio_own, pad_in, pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  logic [6:0] sel_m [NF];

  always #10 clk = ~clk;

  fpmx_router #(.NUM_FUNCS(NF), .NUM_PADS(NP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in),
    .pad_gpio_own(pad_gpio_own), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model of R2/R3/R11 write behaviour
  task automatic bus_write(int addr, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if ((addr >> 2) < NF/2) begin
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < 7; b++)
          if (d[16 + 8*l + b]) sel_m[2*(addr >> 2) + l][b] = d[8*l + b];
    end
  endtask

  task automatic set_sel(int f, logic [6:0] v);
    logic [31:0] d;
    d = '0;
    d[16 + 8*(f%2) +: 7] = 7'h7F;
    d[8*(f%2) +: 7]      = v;
    bus_write((f/2)*4, d);
  endtask

  task automatic bus_read(int addr, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(addr);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] word_m(int w);
    logic [31:0] r;
    r = '0;
    if (w < NF/2) begin
      r[6:0]  = sel_m[2*w];
      r[14:8] = sel_m[2*w+1];
    end
    return r;
  endfunction

  task automatic check_all(string tag);
    logic [NP-1:0] eo, ee;
    logic [NF-1:0] ei;
    eo = '0; ee = '0; ei = '0;
    for (int f = NF-1; f >= 0; f--) begin
      if (sel_m[f] >= 1 && sel_m[f] <= 64) begin
        int p;
        p = int'(sel_m[f]) + 7;
        ei[f] = pad_in[p];
        if (!pad_gpio_own[p]) begin
          eo[p] = fn_out[f];
          ee[p] = fn_oe[f];
        end else begin
          eo[p] = 1'b0;
          ee[p] = 1'b0;
        end
      end
    end
    chk({tag, " pad_out"}, 128'(pad_out), 128'(eo));
    chk({tag, " pad_oe"},  128'(pad_oe),  128'(ee));
    chk({tag, " fn_in"},   128'(fn_in),   128'(ei));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rdata", 128'(bus_rdata), 128'(0));
    check_all("R1 idle");
    bus_read(0, d);
    chk("R1 read word0", 128'(d), 128'(0));
  endtask

  task automatic t_basic();
    logic [31:0] d;
    set_sel(0, 7'd1);
    set_sel(1, 7'd64);
    check_all("R5 pads 8 and 71");
    chk("R5 pad8 oe", 128'(pad_oe[8]), 128'(fn_oe[0]));
    bus_read(0, d);
    chk("R4 R2 read word0", 128'(d), 128'(32'h0000_4001));
    set_sel(31, 7'd30);
    check_all("R2 last word odd lane");
    bus_read(60, d);
    chk("R4 read word15", 128'(d), 128'(word_m(15)));
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bus_write(0, 32'h000F_7F7F);
    check_all("R3 partial mask");
    bus_read(0, d);
    chk("R3 partial mask value", 128'(d), 128'(32'h0000_400F));
    bus_write(0, 32'h0000_1234);
    bus_read(0, d);
    chk("R3 empty mask keeps", 128'(d), 128'(32'h0000_400F));
  endtask

  task automatic t_priority();
    set_sel(5, 7'd10);
    set_sel(2, 7'd10);
    fn_out[2] = 1'b1; fn_out[5] = 1'b0;
    fn_oe[2]  = 1'b0; fn_oe[5]  = 1'b1;
    @(negedge clk);
    chk("R7 lower wins oe", 128'(pad_oe[17]), 128'(0));
    chk("R7 lower wins out", 128'(pad_out[17]), 128'(1));
    set_sel(2, 7'd0);
    chk("R10 detach out", 128'(pad_out[17]), 128'(0));
    chk("R10 takeover oe", 128'(pad_oe[17]), 128'(1));
    check_all("R10 full");
  endtask

  task automatic t_own();
    pad_gpio_own[17] = 1'b1;
    pad_in[17]       = 1'b1;
    @(negedge clk);
    chk("R6 owned pad oe", 128'(pad_oe[17]), 128'(0));
    chk("R9 fn_in owned pad", 128'(fn_in[5]), 128'(1));
    pad_in[17] = 1'b0;
    @(negedge clk);
    chk("R9 fn_in follows", 128'(fn_in[5]), 128'(0));
    check_all("R6 full");
    pad_gpio_own[17] = 1'b0;
  endtask

  task automatic t_unrouted();
    set_sel(6, 7'd100);
    pad_in = '1;
    @(negedge clk);
    chk("R8 high sel fn_in", 128'(fn_in[6]), 128'(0));
    check_all("R8 full");
    set_sel(6, 7'd65);
    chk("R8 sel 65 fn_in", 128'(fn_in[6]), 128'(0));
    pad_in = {8'h5A, 64'hDEAD_BEEF_0123_4567};
  endtask

  task automatic t_addr();
    logic [31:0] d;
    bus_write(4*3 + 2, 32'h7F7F_2A15);
    bus_read(12, d);
    chk("R2 low addr bits", 128'(d), 128'(32'h0000_2A15));
    check_all("R2 word3 routes");
    bus_write(64, 32'h7F7F_0303);
    bus_read(0, d);
    chk("R11 stray write word0", 128'(d), 128'(word_m(0)));
    check_all("R11 routes unchanged");
    bus_read(64, d);
    chk("R4 out of range read", 128'(d), 128'(0));
  endtask

  initial begin
    for (int f = 0; f < NF; f++) sel_m[f] = '0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    fn_out = 32'hA5C3_5A3C; fn_oe = 32'hFFFF_0F0F;
    pad_gpio_own = '0;
    pad_in = {8'h5A, 64'hDEAD_BEEF_0123_4567};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mask();
    t_priority();
    t_own();
    t_unrouted();
    t_addr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule